// File: doc/BRIEF.md
# Serial Channel External/Status Latch

This block is the status and interrupt core of one channel of a multi-protocol serial controller. It watches the channel's modem inputs (clear-to-send, carrier detect and the sync pin), a break/abort detect input, the receiver's hunt state and the transmitter's underrun/end-of-message condition. When any of these five external/status conditions changes, it freezes a snapshot of all five and, if the external/status interrupt is enabled, raises an interrupt request. The snapshot stays frozen until software issues the reset-status command. Software therefore reads live pin levels by issuing that command first and then reading the status word.

The block also keeps the transmit-buffer-empty and receive-character-available flags, and reports a pending external/status interrupt. All of these are packed into one 8-bit read-only status word. Asynchronous pin inputs pass through a two-flop synchronizer before edge detection. Events from the receiver and the transmitter arrive as single-cycle strobes, and commands arrive as a valid strobe with a 3-bit code.

Top module: `extstat_latch`

## Requirements
- R1: After hardware reset, with the active-low pins high, break low, asynchronous mode (mode 0) and the receiver enabled, the status word is 0x20 and `esIntReq` is 0.
- R2: Status bit 0 reports the inverted clear-to-send pin and status bit 1 reports the inverted carrier-detect pin. Each is due 3 clock cycles after the pin changes.
- R3: While the latch is open, any edge of clear-to-send, carrier detect, sync, break (status bit 3, reported non-inverted) or hunt closes the latch on the five bits [4:0]. A rising edge of end-of-message does the same. If `esIntEn` was high, `esIntReq` and status bit 7 go to 1. If it was low, no request is made.
- R4: While the latch is closed, the five snapshot bits stay frozen and further edges are ignored. A pending request stays pending.
- R5: Command code 2 clears the request and opens the latch. One cycle after the command, bits [4:0] show the current levels.
- R6: Status bit 2 reports the inverted sync pin in mode 0. In modes 1, 2 and 3 it reports the hunt flag (1 = hunting), and the sync pin has no effect.
- R7: The hunt flag is set by reset, channel reset, `enterHunt`, a low `rxEnable` and, in mode 3 only, `abortSeen`. It is cleared by `syncFound`. Each of its edges is due on bit 2 two cycles after the strobe and requests an interrupt.
- R8: A transmit underrun in modes 1 to 3 while end-of-message (status bit 4) is low sets that bit and requests an interrupt. An underrun has no effect in mode 0 or while the bit is already set. Command code 5 clears the bit without making a request.
- R9: Status bit 5 (transmit empty) is cleared by `txLoad` and by an accepted underrun, and set by `txDrained`. After an accepted underrun it stays clear until `crcDone`, and `txDrained` is ignored in that interval.
- R10: Status bit 6 (receive character available) equals `rxNotEmpty` as it was one cycle earlier.
- R11: Command code 3 (channel reset) sets hunt, clears end-of-message, sets transmit empty and clears the latch and the request, without raising a new request. Two cycles later the status word shows these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| mode | input | 2 | 0 asynchronous, 1 monosync, 2 bisync, 3 bit-oriented framed |
| clearToSendN | input | 1 | Clear-to-send pin, active low |
| carrierDetN | input | 1 | Carrier-detect pin, active low |
| syncInN | input | 1 | Sync pin, active low |
| breakIn | input | 1 | Break/abort detect level, active high |
| rxEnable | input | 1 | Receiver enable level |
| enterHunt | input | 1 | Strobe: software enters hunt |
| syncFound | input | 1 | Strobe: character synchronization achieved |
| abortSeen | input | 1 | Strobe: abort sequence detected |
| txUnderrun | input | 1 | Strobe: transmit underrun |
| txLoad | input | 1 | Strobe: transmit buffer loaded |
| txDrained | input | 1 | Strobe: transmit buffer became empty |
| crcDone | input | 1 | Strobe: last CRC bit sent |
| rxNotEmpty | input | 1 | Receive FIFO holds at least one character |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code (2 reset status, 3 channel reset, 5 clear end-of-message) |
| esIntEn | input | 1 | External/status interrupt enable |
| statusWord | output | 8 | Status word |
| esIntReq | output | 1 | External/status interrupt request |

## Verification
Each result has its own latency. Pin changes cross two synchronizer flops and the snapshot register, so they are due 3 cycles after the pin moves. Hunt and end-of-message strobes pass through one state flop and the snapshot, so they are due after 2 cycles. The reset-status command, `txLoad`, `txDrained`, `crcDone` and `rxNotEmpty` act after 1 cycle, and channel reset settles after 2. The bench drives every input on a falling edge, waits exactly the due number of rising edges, and samples on the following falling edge. Where a requirement says a stimulus is ignored, the bench holds for more cycles than the longest latency before it reads the word back.

// File: rtl/extstat_pkg.sv
package extstat_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_MONO   = 2'd1,
    MODE_BI     = 2'd2,
    MODE_FRAMED = 2'd3
  } chanMode_e;

  // positions inside the frozen external/status vector
  localparam int ES_BITS = 5;
  localparam int ES_CTS  = 0;
  localparam int ES_DCD  = 1;
  localparam int ES_SH   = 2;
  localparam int ES_BRK  = 3;
  localparam int ES_EOM  = 4;

  // control to datapath strobes
  typedef struct packed {
    logic esClear;
    logic chanReset;
  } ctlStrobe_t;

endpackage

// File: rtl/extstat_sync.sv
module extstat_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/extstat_ctrl.sv
module extstat_ctrl
  import extstat_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter logic [CMD_W-1:0] CMD_ES_RESET   = 3'd2,
  parameter logic [CMD_W-1:0] CMD_CHAN_RESET = 3'd3,
  parameter logic [CMD_W-1:0] CMD_EOM_RESET  = 3'd5
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanMode_e        mode,
  input  logic             rxEnable,
  input  logic             enterHunt,
  input  logic             syncFound,
  input  logic             abortSeen,
  input  logic             txUnderrun,
  input  logic             txLoad,
  input  logic             txDrained,
  input  logic             crcDone,
  input  logic             rxNotEmpty,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdCode,
  output ctlStrobe_t       strobe,
  output logic             huntLevel,
  output logic             eomLevel,
  output logic             txEmpty,
  output logic             rxAvail
);
  logic eomClr, syncMode, underrunTake, huntSetReq, crcBusy;

  always_comb begin
    strobe.esClear   = cmdValid && (cmdCode == CMD_ES_RESET);
    strobe.chanReset = cmdValid && (cmdCode == CMD_CHAN_RESET);
    eomClr           = cmdValid && (cmdCode == CMD_EOM_RESET);
    syncMode         = (mode != MODE_ASYNC);
    underrunTake     = txUnderrun && syncMode && !eomLevel;
    huntSetReq       = enterHunt || !rxEnable ||
                       (abortSeen && (mode == MODE_FRAMED));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      huntLevel <= 1'b1;
      eomLevel  <= 1'b0;
      crcBusy   <= 1'b0;
      txEmpty   <= 1'b1;
      rxAvail   <= 1'b0;
    end else if (strobe.chanReset) begin
      huntLevel <= 1'b1;
      eomLevel  <= 1'b0;
      crcBusy   <= 1'b0;
      txEmpty   <= 1'b1;
      rxAvail   <= 1'b0;
    end else begin
      if (huntSetReq)     huntLevel <= 1'b1;
      else if (syncFound) huntLevel <= 1'b0;

      if (underrunTake)   eomLevel <= 1'b1;
      else if (eomClr)    eomLevel <= 1'b0;

      if (underrunTake)   crcBusy <= 1'b1;
      else if (crcDone)   crcBusy <= 1'b0;

      if (txLoad || underrunTake)              txEmpty <= 1'b0;
      else if (crcDone || (txDrained && !crcBusy)) txEmpty <= 1'b1;

      rxAvail <= rxNotEmpty;
    end
  end
endmodule

// File: rtl/extstat_datapath.sv
module extstat_datapath
  import extstat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  chanMode_e  mode,
  input  logic       ctsSyn,
  input  logic       dcdSyn,
  input  logic       syncSyn,
  input  logic       brkSyn,
  input  logic       huntLevel,
  input  logic       eomLevel,
  input  logic       txEmpty,
  input  logic       rxAvail,
  input  logic       esIntEn,
  output logic [7:0] statusWord,
  output logic       esIntReq,
  output logic       esLatched
);
  logic [ES_BITS-1:0] live, liveQ, snap, edgeHit;
  logic primed, anyEdge;

  always_comb begin
    live[ES_CTS] = ~ctsSyn;
    live[ES_DCD] = ~dcdSyn;
    live[ES_SH]  = (mode == MODE_ASYNC) ? ~syncSyn : huntLevel;
    live[ES_BRK] = brkSyn;
    live[ES_EOM] = eomLevel;
  end

  for (genvar b = 0; b < ES_BITS; b++) begin : g_edge
    if (b == ES_EOM) begin : g_rise
      assign edgeHit[b] = live[b] & ~liveQ[b];
    end else begin : g_both
      assign edgeHit[b] = live[b] ^ liveQ[b];
    end
  end

  assign anyEdge = primed && (|edgeHit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveQ     <= '0;
      snap      <= '0;
      primed    <= 1'b0;
      esLatched <= 1'b0;
      esIntReq  <= 1'b0;
    end else begin
      liveQ <= live;
      if (strobe.chanReset) begin
        primed    <= 1'b0;
        esLatched <= 1'b0;
        esIntReq  <= 1'b0;
      end else begin
        primed <= 1'b1;
        if (strobe.esClear) begin
          esLatched <= 1'b0;
          esIntReq  <= 1'b0;
          snap      <= live;
        end else if (!esLatched) begin
          snap <= live;
          if (anyEdge) begin
            esLatched <= 1'b1;
            esIntReq  <= esIntEn;
          end
        end
      end
    end
  end

  assign statusWord = {esIntReq, rxAvail, txEmpty, snap};
endmodule

// File: rtl/extstat_latch.sv
module extstat_latch
  import extstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W = 3,
  parameter logic [CMD_W-1:0] CMD_ES_RESET   = 3'd2,
  parameter logic [CMD_W-1:0] CMD_CHAN_RESET = 3'd3,
  parameter logic [CMD_W-1:0] CMD_EOM_RESET  = 3'd5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             clearToSendN,
  input  logic             carrierDetN,
  input  logic             syncInN,
  input  logic             breakIn,
  input  logic             rxEnable,
  input  logic             enterHunt,
  input  logic             syncFound,
  input  logic             abortSeen,
  input  logic             txUnderrun,
  input  logic             txLoad,
  input  logic             txDrained,
  input  logic             crcDone,
  input  logic             rxNotEmpty,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             esIntEn,
  output logic [7:0]       statusWord,
  output logic             esIntReq
);
  chanMode_e  modeE;
  ctlStrobe_t strobe;
  logic [3:0] pinSyn;
  logic huntLevel, eomLevel, txEmpty, rxAvail, esLatched;

  assign modeE = chanMode_e'(mode);

  extstat_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({breakIn, syncInN, carrierDetN, clearToSendN}),
    .dout(pinSyn)
  );

  extstat_ctrl #(
    .CMD_W(CMD_W), .CMD_ES_RESET(CMD_ES_RESET),
    .CMD_CHAN_RESET(CMD_CHAN_RESET), .CMD_EOM_RESET(CMD_EOM_RESET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(modeE), .rxEnable(rxEnable),
    .enterHunt(enterHunt), .syncFound(syncFound), .abortSeen(abortSeen),
    .txUnderrun(txUnderrun), .txLoad(txLoad), .txDrained(txDrained),
    .crcDone(crcDone), .rxNotEmpty(rxNotEmpty), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .strobe(strobe), .huntLevel(huntLevel),
    .eomLevel(eomLevel), .txEmpty(txEmpty), .rxAvail(rxAvail)
  );

  extstat_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(modeE),
    .ctsSyn(pinSyn[0]), .dcdSyn(pinSyn[1]), .syncSyn(pinSyn[2]),
    .brkSyn(pinSyn[3]), .huntLevel(huntLevel), .eomLevel(eomLevel),
    .txEmpty(txEmpty), .rxAvail(rxAvail), .esIntEn(esIntEn),
    .statusWord(statusWord), .esIntReq(esIntReq), .esLatched(esLatched)
  );
endmodule

// File: rtl/extstat_checker.sv
module extstat_checker #(
  parameter int CMD_W = 3,
  parameter logic [CMD_W-1:0] CMD_ES_RESET   = 3'd2,
  parameter logic [CMD_W-1:0] CMD_CHAN_RESET = 3'd3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdCode,
  input logic             esIntEn,
  input logic             esIntReq,
  input logic             esLatched,
  input logic             txLoad,
  input logic             rxNotEmpty,
  input logic [7:0]       statusWord
);
  p_req_needs_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(esIntReq) |-> $past(esIntEn));

  p_req_stays_r4: assert property (@(posedge clk) disable iff (!rstN)
    esIntReq && !cmdValid |=> esIntReq);

  p_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    esLatched && !cmdValid |=> esLatched && $stable(statusWord[4:0]));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdCode == CMD_ES_RESET) |=> !esIntReq && !esLatched);

  p_load_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    txLoad && !cmdValid |=> !statusWord[5]);

  p_rx_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && (cmdCode == CMD_CHAN_RESET)) |=> statusWord[6] == $past(rxNotEmpty));

  p_chan_reset_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdCode == CMD_CHAN_RESET) |=> !esIntReq && statusWord[5]);
endmodule

bind extstat_latch extstat_checker #(
  .CMD_W(CMD_W), .CMD_ES_RESET(CMD_ES_RESET), .CMD_CHAN_RESET(CMD_CHAN_RESET)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .esIntEn(esIntEn), .esIntReq(esIntReq), .esLatched(esLatched),
  .txLoad(txLoad), .rxNotEmpty(rxNotEmpty), .statusWord(statusWord)
);

// File: tb/extstat_latch_bench.sv
`timescale 1ns/1ps
module extstat_latch_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic clearToSendN = 1'b1, carrierDetN = 1'b1, syncInN = 1'b1, breakIn = 1'b0;
  logic rxEnable = 1'b1, enterHunt = 1'b0, syncFound = 1'b0, abortSeen = 1'b0;
  logic txUnderrun = 1'b0, txLoad = 1'b0, txDrained = 1'b0, crcDone = 1'b0;
  logic rxNotEmpty = 1'b0, cmdValid = 1'b0, esIntEn = 1'b1;
  logic [2:0] cmdCode = 3'd0;
  logic [7:0] statusWord;
  logic esIntReq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  extstat_latch u_extstat_latch (
    .clk(clk), .rstN(rstN), .mode(mode), .clearToSendN(clearToSendN),
    .carrierDetN(carrierDetN), .syncInN(syncInN), .breakIn(breakIn),
    .rxEnable(rxEnable), .enterHunt(enterHunt), .syncFound(syncFound),
    .abortSeen(abortSeen), .txUnderrun(txUnderrun), .txLoad(txLoad),
    .txDrained(txDrained), .crcDone(crcDone), .rxNotEmpty(rxNotEmpty),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .esIntEn(esIntEn),
    .statusWord(statusWord), .esIntReq(esIntReq)
  );

  // wait n rising edges, then sit on the falling edge
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] expWord, input logic expReq);
    checks++;
    if (statusWord !== expWord || esIntReq !== expReq) begin
      errors++;
      $display("FAIL %s: status %h req %b expected status %h req %b",
               tag, statusWord, esIntReq, expWord, expReq);
    end
  endtask

  task automatic cmd(input logic [2:0] code);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 3'd0;
  endtask

  task automatic resetStatus();
    cmd(3'd2);
  endtask

  task automatic testReset();
    cyc(3);
    chk("R1 reset word", 8'h20, 1'b0);
  endtask

  task automatic testPinLatch();
    clearToSendN = 1'b0;
    cyc(2);
    chk("R2 cts not yet due", 8'h20, 1'b0);
    cyc(1);
    chk("R2 R3 cts latched with request", 8'hA1, 1'b1);
    carrierDetN = 1'b0;
    cyc(5);
    chk("R4 dcd ignored while latched", 8'hA1, 1'b1);
    resetStatus();
    chk("R5 live levels after reset-status", 8'h23, 1'b0);
    cyc(4);
    chk("R5 no late request", 8'h23, 1'b0);
    clearToSendN = 1'b1; carrierDetN = 1'b1;
    cyc(3);
    chk("R2 both pins released", 8'hA0, 1'b1);
    resetStatus();
    chk("R5 cleared", 8'h20, 1'b0);
  endtask

  task automatic testNoEnable();
    esIntEn = 1'b0;
    breakIn = 1'b1;
    cyc(3);
    chk("R3 break latched without request", 8'h28, 1'b0);
    resetStatus();
    breakIn = 1'b0;
    cyc(3);
    chk("R3 break low latched without request", 8'h20, 1'b0);
    resetStatus();
    esIntEn = 1'b1;
  endtask

  task automatic testSyncPin();
    syncInN = 1'b0;
    cyc(3);
    chk("R6 async sync pin", 8'hA4, 1'b1);
    resetStatus();
    syncInN = 1'b1;
    cyc(3);
    chk("R6 async sync pin high", 8'hA0, 1'b1);
    resetStatus();
    mode = 2'd1;
    cyc(1);
    chk("R6 mode 1 shows hunt", 8'hA4, 1'b1);
    resetStatus();
    syncInN = 1'b0;
    cyc(5);
    chk("R6 sync pin ignored in mode 1", 8'h24, 1'b0);
    syncInN = 1'b1;
    cyc(4);
  endtask

  task automatic pulseSyncFound(input string tag);
    syncFound = 1'b1; @(negedge clk); syncFound = 1'b0;
    cyc(1);
    chk(tag, 8'hA0, 1'b1);
    resetStatus();
  endtask

  task automatic testHunt();
    pulseSyncFound("R7 sync found clears hunt");
    enterHunt = 1'b1; @(negedge clk); enterHunt = 1'b0;
    cyc(1);
    chk("R7 enter hunt", 8'hA4, 1'b1);
    resetStatus();
    mode = 2'd3;
    pulseSyncFound("R7 sync found in mode 3");
    abortSeen = 1'b1; @(negedge clk); abortSeen = 1'b0;
    cyc(1);
    chk("R7 abort in mode 3", 8'hA4, 1'b1);
    resetStatus();
    pulseSyncFound("R7 resync after abort");
    mode = 2'd1;
    abortSeen = 1'b1; @(negedge clk); abortSeen = 1'b0;
    cyc(3);
    chk("R7 abort ignored in mode 1", 8'h20, 1'b0);
    rxEnable = 1'b0;
    cyc(2);
    chk("R7 receiver disabled sets hunt", 8'hA4, 1'b1);
    resetStatus();
    rxEnable = 1'b1;
    pulseSyncFound("R7 resync after enable");
  endtask

  task automatic testUnderrun();
    txUnderrun = 1'b1; @(negedge clk); txUnderrun = 1'b0;
    cyc(1);
    chk("R8 R9 underrun sets eom clears empty", 8'h90, 1'b1);
    resetStatus();
    chk("R8 after reset-status", 8'h10, 1'b0);
    txDrained = 1'b1; @(negedge clk); txDrained = 1'b0;
    chk("R9 drained ignored during crc", 8'h10, 1'b0);
    crcDone = 1'b1; @(negedge clk); crcDone = 1'b0;
    chk("R9 crc done sets empty", 8'h30, 1'b0);
    txUnderrun = 1'b1; @(negedge clk); txUnderrun = 1'b0;
    cyc(2);
    chk("R8 underrun with eom high ignored", 8'h30, 1'b0);
    cmd(3'd5);
    cyc(1);
    chk("R8 eom clear makes no request", 8'h20, 1'b0);
    mode = 2'd0;
    cyc(1);
    txUnderrun = 1'b1; @(negedge clk); txUnderrun = 1'b0;
    cyc(3);
    chk("R8 underrun ignored in mode 0", 8'h20, 1'b0);
  endtask

  task automatic testTxRx();
    txLoad = 1'b1; @(negedge clk); txLoad = 1'b0;
    chk("R9 load clears empty", 8'h00, 1'b0);
    txDrained = 1'b1; @(negedge clk); txDrained = 1'b0;
    chk("R9 drained sets empty", 8'h20, 1'b0);
    rxNotEmpty = 1'b1; @(negedge clk);
    chk("R10 receive available", 8'h60, 1'b0);
    rxNotEmpty = 1'b0; @(negedge clk);
    chk("R10 receive drained", 8'h20, 1'b0);
  endtask

  task automatic testChanReset();
    mode = 2'd1;
    clearToSendN = 1'b0;
    cyc(3);
    chk("R11 setup latched", 8'hA1, 1'b1);
    txLoad = 1'b1; @(negedge clk); txLoad = 1'b0;
    txUnderrun = 1'b1; @(negedge clk); txUnderrun = 1'b0;
    cyc(1);
    chk("R4 R11 snapshot frozen under load", 8'h81, 1'b1);
    cmd(3'd3);
    cyc(1);
    chk("R11 channel reset state", 8'h25, 1'b0);
    cyc(3);
    chk("R11 no request after channel reset", 8'h25, 1'b0);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    testReset();
    testPinLatch();
    testNoEnable();
    testSyncPin();
    testHunt();
    testUnderrun();
    testTxRx();
    testChanReset();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule